// File: doc/BRIEF.md
# Programmable Periodic Countdown Timer

A down-counting interval timer driven by a fixed system clock. A prescaler divides the clock into a slow tick, 2500 cycles of 25 MHz by default, which gives one tick every 100 µs. While the timer is enabled, each tick takes one from the live count. When the count is zero, the next tick wraps it to all-ones and counting goes on. The wrap sets a sticky status flag. That flag, gated by an interrupt-enable bit, drives the interrupt request.

Software uses a small register port. Each field has its own write strobe and write data, and its current value is read back on an output. The fields are the reload value, the enable bit, the interrupt enable and the status flag. The live count is read-only. Setting the enable bit copies the reload value into the count. Writing a reload value while the timer runs restarts the count from that value at once. Clearing the enable bit returns the reload value to all-ones.

Top module: `interval_timer`

## Requirements
- R1: After reset the count and the reload value are all-ones, and the enable bit, interrupt enable, status flag and interrupt request are 0.
- R2: A write of 1 to the enable bit while it is 0 loads the count from the reload value on that same clock edge.
- R3: While enabled, the count falls by exactly one every TICK_DIV clock cycles, counted from the enable edge or the last restart, and it does not change between ticks.
- R4: A tick taken when the count is zero makes the count all-ones, not the reload value, and counting continues.
- R5: Each wrap sets the status flag, and the flag stays set until it is cleared.
- R6: A write of 1 to the status flag clears it. A write of 0 leaves it unchanged.
- R7: The interrupt request equals the status flag ANDed with the interrupt enable bit.
- R8: A write of 0 to the enable bit while it is 1 sets the reload value to all-ones.
- R9: A reload write while enabled loads the new value into the count on that edge and restarts the prescaler, so the next decrement comes TICK_DIV cycles later.
- R10: While disabled, the count holds its value and no wrap is generated.
- R11: If a status-clear write and a wrap fall in the same cycle, the status flag ends set.
- R12: The reload value can be written while disabled, and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Reload value write strobe |
| load_wdata | input | CNT_W | Reload value write data |
| en_we | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Enable bit write data |
| ie_we | input | 1 | Interrupt enable write strobe |
| ie_wdata | input | 1 | Interrupt enable write data |
| sts_we | input | 1 | Status flag write strobe |
| sts_wdata | input | 1 | Status write data, 1 clears |
| load_q | output | CNT_W | Reload value read-back |
| en_q | output | 1 | Enable bit read-back |
| ie_q | output | 1 | Interrupt enable read-back |
| cnt_q | output | CNT_W | Live count |
| sts_q | output | 1 | Sticky wrap status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses a 4-bit count and a divide-by-3 prescaler. It sweeps every reload value from 0 to 15 and checks the count after each of 18 ticks against (reload − ticks) mod 16. This separates a correct wrap to all-ones from a reload on wrap, and it places the status set at exactly tick reload+1. Directed cases cover the rest. A restart in mid-count shows whether the prescaler is cleared. A clear write timed onto the wrap edge tests priority. A long idle stretch with the count at zero shows that disabling stops both counting and wraps.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_wdata,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic             ie_we,
  input  logic             ie_wdata,
  input  logic             sts_we,
  input  logic             sts_wdata,
  output logic [CNT_W-1:0] load_q,
  output logic             en_q,
  output logic             ie_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sts_q,
  output logic             irq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  wire en_rise = en_we && en_wdata && !en_q;
  wire en_fall = en_we && !en_wdata && en_q;
  wire restart = en_rise || (load_we && en_q);
  wire tick    = en_q && !restart && (pre_q == PRE_LAST);
  wire wrap    = tick && (cnt_q == '0);
  wire [CNT_W-1:0] load_nxt = en_fall ? '1 : (load_we ? load_wdata : load_q);

  assign irq = sts_q & ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '1;
      cnt_q  <= '1;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      sts_q  <= 1'b0;
      pre_q  <= '0;
    end else begin
      load_q <= load_nxt;
      if (en_we) en_q <= en_wdata;
      if (ie_we) ie_q <= ie_wdata;
      if (wrap) sts_q <= 1'b1;
      else if (sts_we && sts_wdata) sts_q <= 1'b0;
      if (restart) cnt_q <= load_nxt;
      else if (tick) cnt_q <= cnt_q - 1'b1;
      if (!en_q || restart || pre_q == PRE_LAST) pre_q <= '0;
      else pre_q <= pre_q + 1'b1;
    end
  end

  assert_load_on_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && en_we && en_wdata && !load_we) |=> cnt_q == $past(load_q));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !load_we) |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  // also covers R11: the wrap sets the flag even when a clear is written
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (&cnt_q) && sts_q);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(sts_we && sts_wdata)) |=> sts_q);

  assert_preload_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && en_we && !en_wdata) |=> &load_q);

  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(en_we && en_wdata)) |=> ($stable(cnt_q) && !(sts_q && !$past(sts_q))));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  localparam int W = 4;
  localparam int DIV = 3;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_we = 0, en_we = 0, en_wdata = 0, ie_we = 0, ie_wdata = 0, sts_we = 0, sts_wdata = 0;
  logic [W-1:0] load_wdata = '0;
  logic [W-1:0] load_q, cnt_q;
  logic en_q, ie_q, sts_q, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  interval_timer #(.CNT_W(W), .TICK_DIV(DIV)) i_interval_timer (
    .clk(clk), .rst_n(rst_n),
    .load_we(load_we), .load_wdata(load_wdata),
    .en_we(en_we), .en_wdata(en_wdata),
    .ie_we(ie_we), .ie_wdata(ie_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .load_q(load_q), .en_q(en_q), .ie_q(ie_q),
    .cnt_q(cnt_q), .sts_q(sts_q), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_load(input int v);
    load_we = 1; load_wdata = W'(v); @(negedge clk); load_we = 0;
  endtask
  task automatic wr_en(input bit v);
    en_we = 1; en_wdata = v; @(negedge clk); en_we = 0;
  endtask
  task automatic wr_ie(input bit v);
    ie_we = 1; ie_wdata = v; @(negedge clk); ie_we = 0;
  endtask
  task automatic wr_sts(input bit v);
    sts_we = 1; sts_wdata = v; @(negedge clk); sts_we = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cnt", cnt_q, MAXV);
    chk("R1 load", load_q, MAXV);
    chk("R1 en", en_q, 0);
    chk("R1 sts", sts_q, 0);
    chk("R1 irq", irq, 0);

    for (int p = 0; p <= MAXV; p++) begin
      wr_en(0); wr_sts(1); wr_load(p); wr_en(1);
      chk("R2 load on enable", cnt_q, p);
      for (int n = 1; n <= 18; n++) begin
        repeat (DIV - 1) @(negedge clk);
        chk("R3 no early step", cnt_q, (p - n + 1) & MAXV);
        @(negedge clk);
        chk("R3/R4 count", cnt_q, (p - n) & MAXV);
        chk("R5 status", sts_q, (n >= p + 1) ? 1 : 0);
      end
    end

    // R6: clearing the flag
    wr_sts(0);
    chk("R6 write 0 keeps", sts_q, 1);
    // R7: interrupt gating
    chk("R7 masked", irq, 0);
    wr_ie(1);
    chk("R7 unmasked", irq, 1);
    wr_sts(1);
    chk("R6 write 1 clears", sts_q, 0);
    chk("R7 after clear", irq, 0);

    // R8: disable resets the reload value
    wr_load(6);
    chk("R9 reload restarts count", cnt_q, 6);
    wr_en(0);
    chk("R8 reload to ones", load_q, MAXV);

    // R9: restart mid-count clears the prescaler
    wr_load(10); wr_en(1);
    repeat (2 * DIV + 1) @(negedge clk);
    chk("R9 pre restart", cnt_q, 8);
    wr_load(5);
    chk("R9 restart value", cnt_q, 5);
    repeat (DIV - 1) @(negedge clk);
    chk("R9 prescaler restarted", cnt_q, 5);
    @(negedge clk);
    chk("R9 next step", cnt_q, 4);

    // R10: disabled holds the count at zero with no wrap
    wr_en(0); wr_load(1); wr_en(1);
    repeat (DIV) @(negedge clk);
    chk("R10 setup", cnt_q, 0);
    wr_en(0); wr_sts(1);
    repeat (10 * DIV) @(negedge clk);
    chk("R10 count held", cnt_q, 0);
    chk("R10 no wrap", sts_q, 0);

    // R12: reload write while disabled
    wr_load(9);
    chk("R12 reload readback", load_q, 9);
    chk("R12 count unchanged", cnt_q, 0);

    // R11: clear on the wrap edge
    wr_load(0); wr_en(1);
    chk("R11 setup", sts_q, 0);
    repeat (DIV - 1) @(negedge clk);
    wr_sts(1);
    chk("R11 set wins", sts_q, 1);
    chk("R11 wrapped", cnt_q, MAXV);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule